// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a synchronous DRAM from power-on to a state where normal traffic may begin. Out of reset it holds clock-enable and every data-mask lane high and drives only no-op commands for a settable idle time, at least 200 us. After that it issues one precharge of all banks and a settable number of auto-refresh commands (two or more), in either order. It closes with a mode register set whose address word is packed from the configured CAS latency, burst type, burst length and write-burst mode.

All timing is given in nanoseconds and turned into clock counts from a clock-frequency parameter, always rounded up. After a precharge the next command waits the row-precharge time. After every refresh the next command waits the row-cycle time. After the mode register set the block waits two clocks, then raises a done flag that holds until reset and releases the data-mask lanes. All configuration is fixed by parameters. Every output is a flop, so the block can drive device pins directly.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held and in the cycle after it, CKE is 1, every DQM bit is 1, the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-op), address and bank are 0 and init_done is 0. CKE stays 1 at all times.
- R2: The first command other than no-op appears exactly IDLE_CYC = ceil(IDLE_NS*CLK_MHZ/1000) clocks after reset is released. Before that, only no-op is driven with DQM all ones. A new reset starts the whole sequence again.
- R3: The precharge is coded 4'b0010 and drives address bit 10 high, with every other address bit and the bank at 0, so that all banks are selected.
- R4: Exactly REFRESH_CNT auto-refresh commands (4'b0001) are issued, with address and bank at 0. REFRESH_CNT is a parameter of at least 2.
- R5: With REFRESH_FIRST=0 the order is precharge, then the refreshes. With REFRESH_FIRST=1 it is the refreshes, then the precharge. The mode register set (4'b0000) is always the last command.
- R6: The command after a precharge comes exactly ceil(T_RP_NS*CLK_MHZ/1000) clocks later. The command after each refresh comes exactly ceil(T_RC_NS*CLK_MHZ/1000) clocks later. Both counts are at least 1.
- R7: During the mode register set the address holds the burst-length code in bits [2:0] (1→000, 2→001, 4→010, 8→011, full page given as 0→111). Bit 3 is the burst type (1 = interleaved). Bits [6:4] hold the CAS latency in binary (1, 2 or 3). Bits [8:7] are 00. Bit 9 is 1 when writes are single-location. Bit 10 and the bank are 0.
- R8: init_done rises exactly 2 clocks after the mode register set and then stays at 1 until reset. From the cycle it rises, DQM is all zeros and only no-op is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the device |
| dqm | output | DQM_W | Data-mask lanes, high until init_done |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus (precharge-all flag, mode word) |
| ba | output | BANK_W | Bank select, always 0 |
| init_done | output | 1 | Initialization complete, held until reset |

## Verification
On every cycle the assertions check the following:
- CKE stays high.
- Only the four legal command codes appear.
- Only no-op with DQM high is driven during the idle hold.
- A precharge always carries the all-banks flag.
- A mode register set always carries the packed mode word.
- The spacing after each precharge, refresh and mode register set is exact.
- init_done holds and stays quiet.

The bench scenarios cover what the assertions cannot:
- The absolute time of the first command after reset.
- The refresh count and both orderings.
- Correct mode words for three sets of settings, including full page, interleaved bursts, CAS latency 1 and single-location writes.
- A full restart after a second reset.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command codes on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_SEQ  = 2'd1,
    ST_DONE = 2'd2
  } init_state_e;

  // Nanoseconds to clocks, rounded up, never below one
  function automatic int ns_to_clk(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // Burst length to field code; 0 means full page
  function automatic logic [2:0] burst_code(input int len);
    case (len)
      1:       return 3'b000;
      2:       return 3'b001;
      4:       return 3'b010;
      8:       return 3'b011;
      default: return 3'b111;
    endcase
  endfunction

endpackage

// File: rtl/sdram_mode_pack.sv
module sdram_mode_pack #(
  parameter int ADDR_W      = 11,
  parameter int CAS_LAT     = 3,
  parameter int BURST_LEN   = 4,
  parameter bit INTERLEAVE  = 1'b0,
  parameter bit SINGLE_WR   = 1'b0
) (
  output logic [ADDR_W-1:0] word
);
  import sdram_init_pkg::*;

  always_comb begin
    word      = '0;
    word[2:0] = burst_code(BURST_LEN);
    word[3]   = INTERLEAVE;
    word[6:4] = 3'(CAS_LAT);
    word[8:7] = 2'b00;
    word[9]   = SINGLE_WR;
  end
endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                cnt <= CNT_W'(RST_VAL);
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  a_r2_no_reload_while_busy: assert property (@(posedge clk) disable iff (rst)
    load |-> expired);
endmodule

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int REFRESH_CNT   = 2,
  parameter bit REFRESH_FIRST = 1'b0,
  parameter int T_RP_CYC      = 2,
  parameter int T_RC_CYC      = 7,
  parameter int MRS_WAIT      = 2,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expired,
  output logic             issue,
  output sdr_cmd_e         cmd_sel,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             go_done,
  output logic             in_hold
);
  localparam int NSTEP  = REFRESH_CNT + 2;
  localparam int STEP_W = $clog2(NSTEP + 1);

  init_state_e       state;
  logic [STEP_W-1:0] step;
  logic              fire;

  // Command selected by the step counter; the ordering variant is a parameter
  generate
    if (REFRESH_FIRST) begin : g_ref_first
      always_comb begin
        if (step < STEP_W'(REFRESH_CNT))       cmd_sel = CMD_REF;
        else if (step == STEP_W'(REFRESH_CNT)) cmd_sel = CMD_PRE;
        else                                   cmd_sel = CMD_MRS;
      end
    end else begin : g_pre_first
      always_comb begin
        if (step == '0)                        cmd_sel = CMD_PRE;
        else if (step <= STEP_W'(REFRESH_CNT)) cmd_sel = CMD_REF;
        else                                   cmd_sel = CMD_MRS;
      end
    end
  endgenerate

  always_comb begin
    case (cmd_sel)
      CMD_PRE: load_val = CNT_W'(T_RP_CYC - 1);
      CMD_REF: load_val = CNT_W'(T_RC_CYC - 1);
      default: load_val = CNT_W'(MRS_WAIT - 1);
    endcase
  end

  assign fire    = (state != ST_DONE) && expired;
  assign issue   = fire && (step < STEP_W'(NSTEP));
  assign load    = issue;
  assign go_done = fire && (step == STEP_W'(NSTEP));
  assign in_hold = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HOLD;
      step  <= '0;
    end else if (issue) begin
      state <= ST_SEQ;
      step  <= step + 1'b1;
    end else if (go_done) begin
      state <= ST_DONE;
    end
  end

  a_r5_mrs_is_last: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE) |-> (step == STEP_W'(NSTEP)));
endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ       = 100,
  parameter int IDLE_NS       = 200000,
  parameter int T_RP_NS       = 20,
  parameter int T_RC_NS       = 70,
  parameter int REFRESH_CNT   = 2,
  parameter bit REFRESH_FIRST = 1'b0,
  parameter int CAS_LAT       = 3,
  parameter int BURST_LEN     = 4,
  parameter bit INTERLEAVE    = 1'b0,
  parameter bit SINGLE_WR     = 1'b0,
  parameter int ADDR_W        = 11,
  parameter int BANK_W        = 2,
  parameter int DQM_W         = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba,
  output logic              init_done
);
  localparam int IDLE_CYC = ns_to_clk(IDLE_NS, CLK_MHZ);
  localparam int T_RP_CYC = ns_to_clk(T_RP_NS, CLK_MHZ);
  localparam int T_RC_CYC = ns_to_clk(T_RC_NS, CLK_MHZ);
  localparam int MRS_WAIT = 2;
  localparam int MAX_WAIT = (IDLE_CYC > T_RC_CYC) ? IDLE_CYC : T_RC_CYC;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int AP_BIT   = 10;

  logic [ADDR_W-1:0] mode_word;
  logic              expired, issue, load, go_done, in_hold;
  logic [CNT_W-1:0]  load_val;
  sdr_cmd_e          cmd_sel;
  sdr_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic              cke_q;
  logic              dqm_q;

  sdram_mode_pack #(
    .ADDR_W(ADDR_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN),
    .INTERLEAVE(INTERLEAVE), .SINGLE_WR(SINGLE_WR)
  ) u_mode (
    .word(mode_word)
  );

  sdram_wait_timer #(.CNT_W(CNT_W), .RST_VAL(IDLE_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .expired(expired)
  );

  sdram_init_ctrl #(
    .REFRESH_CNT(REFRESH_CNT), .REFRESH_FIRST(REFRESH_FIRST),
    .T_RP_CYC(T_RP_CYC), .T_RC_CYC(T_RC_CYC), .MRS_WAIT(MRS_WAIT), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .expired(expired), .issue(issue), .cmd_sel(cmd_sel),
    .load(load), .load_val(load_val), .go_done(go_done), .in_hold(in_hold)
  );

  // Registered pin drivers
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      done_q <= 1'b0;
      cke_q  <= 1'b1;
      dqm_q  <= 1'b1;
    end else begin
      cke_q  <= 1'b1;
      cmd_q  <= issue ? cmd_sel : CMD_NOP;
      addr_q <= '0;
      if (issue && cmd_sel == CMD_PRE) addr_q[AP_BIT] <= 1'b1;
      if (issue && cmd_sel == CMD_MRS) addr_q <= mode_word;
      done_q <= done_q | go_done;
      dqm_q  <= ~(done_q | go_done);
    end
  end

  assign cke       = cke_q;
  assign dqm       = {DQM_W{dqm_q}};
  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign addr      = addr_q;
  assign ba        = '0;
  assign init_done = done_q;

  // Spacing monitor: clocks since the last command seen on the pins
  logic [15:0] gap_cnt;
  sdr_cmd_e    last_cmd;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt  <= '0;
      last_cmd <= CMD_NOP;
    end else if (cmd_q != CMD_NOP) begin
      gap_cnt  <= 16'd1;
      last_cmd <= cmd_q;
    end else if (gap_cnt != 16'hFFFF) begin
      gap_cnt  <= gap_cnt + 1'b1;
    end
  end

  a_r1_cke_high: assert property (@(posedge clk) disable iff (rst) cke);
  a_r2_hold_quiet: assert property (@(posedge clk) disable iff (rst)
    in_hold |-> (cmd_q == CMD_NOP && dqm == {DQM_W{1'b1}}));
  a_r3_precharge_all: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (addr[AP_BIT] && $countones(addr) == 1 && ba == '0));
  a_r7_mode_word: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS) |-> (addr == mode_word && ba == '0));
  a_r4_legal_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_q inside {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS});
  a_r6_rp_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP && last_cmd == CMD_PRE) |-> (gap_cnt == 16'(T_RP_CYC)));
  a_r6_rc_gap: assert property (@(posedge clk) disable iff (rst)
    (cmd_q != CMD_NOP && last_cmd == CMD_REF) |-> (gap_cnt == 16'(T_RC_CYC)));
  a_r8_done_after_mrs: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done) |-> (last_cmd == CMD_MRS && gap_cnt == 16'(MRS_WAIT)));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cmd_q == CMD_NOP && dqm == '0));
endmodule

// File: tb/sim_sdram_pwrup_seq.sv
`timescale 1ns/1ps

module sim_probe (
  input logic        clk,
  input logic        rst,
  input logic        cke,
  input logic [3:0]  dqm,
  input logic [3:0]  cmd,
  input logic [10:0] addr,
  input logic [1:0]  ba,
  input logic        done
);
  int          cyc;
  logic [3:0]  ev_cmd  [8];
  int          ev_t    [8];
  logic [10:0] ev_addr [8];
  logic [1:0]  ev_ba   [8];
  int          n_ev;
  int          done_t;
  int          bad_pre;
  int          bad_post;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      n_ev = 0; done_t = -1; bad_pre = 0; bad_post = 0;
    end else begin
      if (cke !== 1'b1) bad_pre++;
      if (done_t < 0 && done === 1'b1) done_t = cyc;
      if (done_t >= 0) begin
        if (done !== 1'b1 || dqm !== 4'h0 || cmd !== 4'b0111) bad_post++;
      end else begin
        if (dqm !== 4'hF) bad_pre++;
        if (cmd !== 4'b0111) begin
          if (n_ev < 8) begin
            ev_cmd[n_ev] = cmd; ev_t[n_ev] = cyc;
            ev_addr[n_ev] = addr; ev_ba[n_ev] = ba;
          end
          n_ev++;
        end
      end
    end
  end
endmodule

module sim_sdram_pwrup_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic        cke0, cke1, cke2;
  logic [3:0]  dqm0, dqm1, dqm2;
  logic [3:0]  cmd0, cmd1, cmd2;
  logic [10:0] addr0, addr1, addr2;
  logic [1:0]  ba0, ba1, ba2;
  logic        done0, done1, done2;

  // Defaults: 100 MHz, 200 us hold, tRP 2, tRC 7, precharge first, BL4 seq CL3
  sdram_pwrup_seq u0 (
    .clk(clk), .rst(rst), .cke(cke0), .dqm(dqm0),
    .cs_n(cmd0[3]), .ras_n(cmd0[2]), .cas_n(cmd0[1]), .we_n(cmd0[0]),
    .addr(addr0), .ba(ba0), .init_done(done0));

  // 50 MHz, 10 us hold, tRP 1, tRC 4, three refreshes first, full page interleaved CL2, single writes
  sdram_pwrup_seq #(
    .CLK_MHZ(50), .IDLE_NS(10000), .T_RP_NS(20), .T_RC_NS(70), .REFRESH_CNT(3),
    .REFRESH_FIRST(1'b1), .CAS_LAT(2), .BURST_LEN(0), .INTERLEAVE(1'b1), .SINGLE_WR(1'b1)
  ) u1 (
    .clk(clk), .rst(rst), .cke(cke1), .dqm(dqm1),
    .cs_n(cmd1[3]), .ras_n(cmd1[2]), .cas_n(cmd1[1]), .we_n(cmd1[0]),
    .addr(addr1), .ba(ba1), .init_done(done1));

  // 100 MHz, 1 us hold, tRP 15ns->2, tRC 60ns->6, BL8 seq CL1
  sdram_pwrup_seq #(
    .IDLE_NS(1000), .T_RP_NS(15), .T_RC_NS(60), .CAS_LAT(1), .BURST_LEN(8)
  ) u2 (
    .clk(clk), .rst(rst), .cke(cke2), .dqm(dqm2),
    .cs_n(cmd2[3]), .ras_n(cmd2[2]), .cas_n(cmd2[1]), .we_n(cmd2[0]),
    .addr(addr2), .ba(ba2), .init_done(done2));

  sim_probe p0 (.clk(clk), .rst(rst), .cke(cke0), .dqm(dqm0), .cmd(cmd0), .addr(addr0), .ba(ba0), .done(done0));
  sim_probe p1 (.clk(clk), .rst(rst), .cke(cke1), .dqm(dqm1), .cmd(cmd1), .addr(addr1), .ba(ba1), .done(done1));
  sim_probe p2 (.clk(clk), .rst(rst), .cke(cke2), .dqm(dqm2), .cmd(cmd2), .addr(addr2), .ba(ba2), .done(done2));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests_run++;
    if (!ok) begin
      tests_failed++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Compare one probe trace against the expected command list
  task automatic check_trace(input int which, input int exp_n, input logic [3:0] ec [8],
                             input int et [8], input logic [10:0] mode, input int exp_done);
    logic [3:0]  c [8];
    int          t [8];
    logic [10:0] a [8];
    logic [1:0]  b [8];
    int n, dt, bpre, bpost;
    case (which)
      0: begin c = p0.ev_cmd; t = p0.ev_t; a = p0.ev_addr; b = p0.ev_ba; n = p0.n_ev;
               dt = p0.done_t; bpre = p0.bad_pre; bpost = p0.bad_post; end
      1: begin c = p1.ev_cmd; t = p1.ev_t; a = p1.ev_addr; b = p1.ev_ba; n = p1.n_ev;
               dt = p1.done_t; bpre = p1.bad_pre; bpost = p1.bad_post; end
      default: begin c = p2.ev_cmd; t = p2.ev_t; a = p2.ev_addr; b = p2.ev_ba; n = p2.n_ev;
               dt = p2.done_t; bpre = p2.bad_pre; bpost = p2.bad_post; end
    endcase
    check(n == exp_n, "R4 command count", n, exp_n);
    for (int i = 0; i < exp_n && i < 8; i++) begin
      check(c[i] == ec[i], "R5 command order", int'(c[i]), int'(ec[i]));
      check(t[i] == et[i], (i == 0) ? "R2 first command time" : "R6 command spacing", t[i], et[i]);
      check(b[i] == 2'b00, "R3 bank zero", int'(b[i]), 0);
      if (ec[i] == PRE) check(a[i] == 11'h400, "R3 precharge-all address", int'(a[i]), 'h400);
      if (ec[i] == REF) check(a[i] == 11'h000, "R4 refresh address", int'(a[i]), 0);
      if (ec[i] == MRS) check(a[i] == mode, "R7 mode word", int'(a[i]), int'(mode));
    end
    check(dt == exp_done, "R8 done time", dt, exp_done);
    check(bpre == 0, "R1 cke/dqm during init", bpre, 0);
    check(bpost == 0, "R8 quiet and sticky after done", bpost, 0);
  endtask

  task automatic test_reset_state();
    @(negedge clk);
    check(cke0 == 1'b1, "R1 cke", cke0, 1);
    check(dqm0 == 4'hF, "R1 dqm", dqm0, 'hF);
    check(cmd0 == NOP, "R1 nop", cmd0, NOP);
    check(addr0 == 11'h0 && ba0 == 2'b0, "R1 addr/ba", addr0, 0);
    check(done0 == 1'b0 && done1 == 1'b0 && done2 == 1'b0, "R1 done low", done0, 0);
  endtask

  // u0: PRE@20000, REF@20002, REF@20009, MRS@20016, done@20018; word BL4=010, CL3=011 -> 0x032
  task automatic test_default_order();
    logic [3:0] ec [8] = '{PRE, REF, REF, MRS, NOP, NOP, NOP, NOP};
    int         et [8] = '{20000, 20002, 20009, 20016, 0, 0, 0, 0};
    check_trace(0, 4, ec, et, 11'h032, 20018);
  endtask

  // u1: REF@500, REF@504, REF@508, PRE@512, MRS@513, done@515
  // word: full page 111 | interleave bit3 | CL2 010<<4 | single write bit9 -> 0x22F
  task automatic test_refresh_first();
    logic [3:0] ec [8] = '{REF, REF, REF, PRE, MRS, NOP, NOP, NOP};
    int         et [8] = '{500, 504, 508, 512, 513, 0, 0, 0};
    check_trace(1, 5, ec, et, 11'h22F, 515);
  endtask

  // u2: PRE@100, REF@102, REF@108, MRS@114, done@116; word BL8=011, CL1=001 -> 0x013
  task automatic test_short_cl1();
    logic [3:0] ec [8] = '{PRE, REF, REF, MRS, NOP, NOP, NOP, NOP};
    int         et [8] = '{100, 102, 108, 114, 0, 0, 0, 0};
    check_trace(2, 4, ec, et, 11'h013, 116);
  endtask

  // A second reset returns everything to the reset state and reruns the sequence
  task automatic test_restart();
    @(posedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(done0 == 1'b0 && done1 == 1'b0, "R1 done cleared by reset", done0, 0);
    check(dqm1 == 4'hF && cmd1 == NOP, "R1 reset state after rerun reset", dqm1, 'hF);
    @(posedge clk); #1 rst = 1'b0;
    repeat (200) @(posedge clk);
    @(negedge clk);
    check(done1 == 1'b0, "R2 no early done on restart", done1, 0);
    test_short_cl1();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    test_reset_state();
    @(posedge clk); #1 rst = 1'b0;
    wait (p0.done_t > 0);
    repeat (20) @(posedge clk);
    test_default_order();
    test_refresh_first();
    test_short_cl1();
    test_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule